// File: doc/BRIEF.md
# Edge-Detect Interrupt Unit

This unit watches the 24 edge-capable I/O lines of a digital I/O block (three ports of eight lines) and turns selected transitions into interrupt requests. Each line carries its own direction-select bit and enable bit, both supplied by a separate register bank. When an enabled line makes a transition in its chosen direction, the unit sets a sticky identification bit for that line and drives an active-high interrupt request.

Software polls a three-bit pending summary, one bit per port, to find which ports hold set identification bits. It then reads the identification vector and acknowledges by writing a zero to each bit it has handled. Pin levels are resynchronised before comparison, and a warm-up interval after reset keeps the first samples from posing as edges.

Top module: `edge_irq_unit`

## Requirements
- R1: Line n belongs to port n/8. Pending bit p (p = 0..2) is 1 exactly when at least one of id bits 8p+7..8p is set.
- R2: A direction bit of 1 makes a line react to a low-to-high change at its pin, a direction bit of 0 to a high-to-low change; a change in the other direction leaves the id bit clear.
- R3: A line whose enable bit is 0 never sets its id bit, so with all enable bits 0 no new id bit appears.
- R4: A set id bit stays set until a clear write (clr_we_i high) carries 0 in that bit position; a 1 in that position, or no write, leaves it set.
- R5: irq_o is high exactly when at least one id bit is set.
- R6: If an edge and a clearing 0 for the same line land in the same cycle, the id bit ends up set.
- R7: Reset clears every id bit, and pins held high from reset produce no id bit once reset is released.
- R8: A pin level that is stable before rising clock edge k sets the id bit at clock edge k+2 (it is not yet set after edge k+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 24 | Physical levels of the edge-capable lines |
| dir_i | input | 24 | Per-line direction select, 1 = low-to-high |
| en_i | input | 24 | Per-line detect enable |
| clr_we_i | input | 1 | Clear write strobe for the id bits |
| clr_data_i | input | 24 | Clear write data; a 0 clears the matching id bit |
| id_o | output | 24 | Sticky per-line identification bits |
| pend_o | output | 3 | Per-port pending summary |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench holds all pins high through reset with every line enabled; a design that treats the reset value of its sample registers as a real level would raise a false rising edge there. It times an edge to coincide with a clearing write, where a design giving the clear priority would lose the event, and writes ones to set bits to catch a clear that ignores the data. Edges of the wrong direction and edges on disabled lines are checked to leave the id vector at zero, and the one-cycle-early sample catches a missing synchroniser stage.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int unsigned LINES_PER_PORT = 8;
  localparam int unsigned EDGE_PORTS     = 3;
  localparam int unsigned EDGE_LINES     = LINES_PER_PORT * EDGE_PORTS;
  localparam int unsigned WARMUP_CYCLES  = 3;
endpackage

// File: rtl/eiu_line_sync.sv
module eiu_line_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned WARMUP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lines_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             valid_o
);
  localparam int unsigned CW = $clog2(WARMUP + 1);

  logic [WIDTH-1:0] meta_q, cur_q, prev_q;
  logic [CW-1:0]    fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      meta_q <= lines_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
      if (fill_q != CW'(WARMUP)) fill_q <= fill_q + 1'b1;
    end
  end

  // prev holds a real pin sample only after the pipeline has filled
  assign valid_o = (fill_q == CW'(WARMUP));
  assign cur_o   = cur_q;
  assign prev_o  = prev_q;

  AST_WARMUP_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R7
endmodule

// File: rtl/eiu_id_bank.sv
module eiu_id_bank #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] id_o
);
  logic [WIDTH-1:0] id_q, clr_mask;

  assign clr_mask = clr_we_i ? ~clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= '0;
    else         id_q <= (id_q & ~clr_mask) | set_i; // new edge wins
  end

  assign id_o = id_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    AST_ID_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(id_q[i]) |-> $past(set_i[i])); // R2
    AST_ID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_q[i] && !(clr_we_i && !clr_data_i[i])) |=> id_q[i]); // R4
    AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> id_q[i]); // R6
  end
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import eiu_pkg::*;
#(
  parameter int unsigned PORT_W = LINES_PER_PORT,
  parameter int unsigned PORTS  = EDGE_PORTS,
  parameter int unsigned WARMUP = WARMUP_CYCLES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PORT_W*PORTS-1:0] lines_i,
  input  logic [PORT_W*PORTS-1:0] dir_i,
  input  logic [PORT_W*PORTS-1:0] en_i,
  input  logic                    clr_we_i,
  input  logic [PORT_W*PORTS-1:0] clr_data_i,
  output logic [PORT_W*PORTS-1:0] id_o,
  output logic [PORTS-1:0]        pend_o,
  output logic                    irq_o
);
  localparam int unsigned N = PORT_W * PORTS;

  logic [N-1:0] cur, prev, rise, fall, hit;
  logic         smp_valid;

  eiu_line_sync #(.WIDTH(N), .WARMUP(WARMUP)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (lines_i),
    .cur_o   (cur),
    .prev_o  (prev),
    .valid_o (smp_valid)
  );

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign hit  = smp_valid ? (en_i & ((dir_i & rise) | (~dir_i & fall))) : '0;

  eiu_id_bank #(.WIDTH(N)) u_ids (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hit),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .id_o       (id_o)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_pend
    assign pend_o[p] = |id_o[p*PORT_W +: PORT_W];
  end

  assign irq_o = |pend_o;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(id_o[i]) |-> $past(en_i[i])); // R3
  end

  AST_PEND_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != '0) |-> irq_o); // R5
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_we_i)); // R4
endmodule

// File: tb/edge_irq_unit_tb.sv
module edge_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  lines_i = '1;
  logic [N-1:0]  dir_i = '1;
  logic [N-1:0]  en_i = '1;
  logic          clr_we_i = 1'b0;
  logic [N-1:0]  clr_data_i = '0;
  logic [N-1:0]  id_o;
  logic [2:0]    pend_o;
  logic          irq_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  edge_irq_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(lines_i), .dir_i(dir_i),
    .en_i(en_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .id_o(id_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_all();
    clr_we_i = 1'b1; clr_data_i = '0;
    step(1);
    clr_we_i = 1'b0; clr_data_i = '1;
  endtask

  // R7: pins high through reset, every line enabled for rising edges
  task automatic t_reset();
    lines_i = '1; dir_i = '1; en_i = '1;
    rst_ni = 1'b0;
    step(3);
    check("R7 id after reset", id_o, 0);
    check("R7 irq after reset", irq_o, 0);
    rst_ni = 1'b1;
    step(6);
    check("R7 no spurious edge", id_o, 0);
    check("R7 no spurious pend", pend_o, 0);
  endtask

  // R2 falling polarity on line 3, R8 latency, R1 port mapping, R5 irq
  task automatic t_fall_latency();
    dir_i = '0; en_i = '1;
    lines_i[3] = 1'b0;
    step(2);
    check("R8 not yet after k+1", id_o, 0);
    step(1);
    check("R8 set at k+2", id_o, 24'h000008);
    check("R1 pend port0", pend_o, 3'b001);
    check("R5 irq high", irq_o, 1);
    clear_all();
    check("R5 irq low after clear", irq_o, 0);
    lines_i = '1; // rising edges, ignored by falling polarity
    step(5);
    check("R2 wrong direction ignored", id_o, 0);
  endtask

  // R2 rising polarity, R1 port 2, R4 sticky and write-one no effect
  task automatic t_rise_sticky();
    lines_i = '0; dir_i = '1; en_i = '1;
    step(5);
    clear_all();
    check("R2 falls ignored under rising", id_o, 0);
    lines_i[20] = 1'b1;
    step(4);
    check("R2 rise sets line 20", id_o, 24'h100000);
    check("R1 pend port2", pend_o, 3'b100);
    lines_i[20] = 1'b0;
    step(6);
    check("R4 sticky without write", id_o, 24'h100000);
    clr_we_i = 1'b1; clr_data_i = '1;
    step(1);
    clr_we_i = 1'b0;
    check("R4 write of one keeps bit", id_o, 24'h100000);
    clr_we_i = 1'b1; clr_data_i = ~24'h100000;
    step(1);
    clr_we_i = 1'b0; clr_data_i = '1;
    check("R4 write of zero clears", id_o, 0);
  endtask

  // R3 disabled lines, R1 port 1
  task automatic t_enable();
    lines_i = '0; dir_i = '1;
    step(5);
    clear_all();
    en_i = '0;
    lines_i = '1;
    step(5);
    check("R3 all disabled no id", id_o, 0);
    lines_i = '0;
    en_i = 24'h000200;
    step(5);
    clear_all();
    lines_i = '1;
    step(5);
    check("R3 only enabled line 9 sets", id_o, 24'h000200);
    check("R1 pend port1", pend_o, 3'b010);
    clear_all();
  endtask

  // R6 edge coinciding with clearing write
  task automatic t_collide();
    lines_i = '0; dir_i = '1; en_i = '1;
    step(5);
    clear_all();
    lines_i[12] = 1'b1;
    step(4);
    lines_i[12] = 1'b0;
    step(5);
    check("R6 precondition set", id_o, 24'h001000);
    lines_i[12] = 1'b1; // change before edge k; id sets at k+2
    step(2);
    clr_we_i = 1'b1; clr_data_i = '0;
    step(1);
    clr_we_i = 1'b0; clr_data_i = '1;
    check("R6 edge wins over clear", id_o, 24'h001000);
    clear_all();
    check("R6 later clear works", id_o, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fall_latency();
        t_rise_sticky();
        t_enable();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule